// File: doc/BRIEF.md
# Packed-Counter Branch Direction Predictor

This block predicts the direction of conditional branches for a 64-bit in-order core. It holds a table of 2-bit saturating counters. The table sits in a memory that is eight bits wide, so each word carries four counters. An update therefore rewrites one 2-bit field of a word and leaves the other three fields as they were. A 4096-entry table maps onto 1024 words, and a 512-entry table maps onto 128 words.

A parameter fixes how the table is indexed. Bimodal mode uses PC bits alone. Gselect mode joins PC bits with the global history. Gshare mode XORs PC bits with the global history. The fetch stage presents a PC on the lookup port and gets back a taken or not-taken prediction in the same cycle, along with the history value that produced it. That history value travels with the branch down the pipe. When the branch resolves, the core presents its PC, the carried history, the real outcome and a mispredict flag on the update port.

The block also keeps a speculative global history. Each lookup shifts its predicted direction into the history. A mispredict rewinds the history to the carried value and appends the real outcome.

Top module: `pkctr_bp`

## Requirements
- R1: After reset every counter holds 2'b01, the global history is all zeros, and every lookup predicts not-taken until an update changes its entry.
- R2: `lk_taken` is bit 1 of the counter selected by the lookup index.
- R3: An update increments the selected counter when `up_taken` is 1 and decrements it when `up_taken` is 0. A counter at 3 stays at 3 on a taken update, and a counter at 0 stays at 0 on a not-taken update.
- R4: Index bits [1:0] pick a field of the word. Field k sits at word bits [2k+1:2k]. The remaining index bits form the word address. An update changes only the selected field.
- R5: Bimodal mode uses index = pc[PC_LSB +: IDX_W], where IDX_W = log2(ENTRIES). This mode works with a 512-entry table.
- R6: Gselect mode uses index = {pc[PC_LSB +: IDX_W-HIST_W], history}.
- R7: Gshare mode uses index = pc[PC_LSB +: IDX_W] XOR the history zero-extended to IDX_W bits.
- R8: A lookup and an update to the same word in the same cycle give the lookup the counter value from before the update. The new value is visible from the next cycle on. Updates in consecutive cycles to fields of one word all take effect.
- R9: `lk_hist` shows the history used by the current lookup. After each cycle with `lk_valid` and no restore, the history becomes {history[HIST_W-2:0], lk_taken}.
- R10: When `up_valid` and `up_mispred` are both 1, the next history is {up_hist[HIST_W-2:0], up_taken}. This takes priority over a lookup shift in the same cycle.
- R11: The update index is formed from `up_pc` and `up_hist`, never from the current speculative history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup present this cycle; shifts the speculative history |
| lk_pc | input | PC_W | Fetch PC of the branch being predicted |
| lk_taken | output | 1 | Predicted direction (1 = taken) |
| lk_hist | output | HIST_W | History used for this lookup, carried with the branch |
| up_valid | input | 1 | Resolved branch present this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_hist | input | HIST_W | History that was used when the branch was predicted |
| up_taken | input | 1 | Actual outcome of the resolved branch |
| up_mispred | input | 1 | The prediction was wrong; restore the history |

## Verification
A wrong counter value, such as a lost saturation, a neighbouring field that gets overwritten, or a write to the wrong word, stays hidden until that entry is looked up again. It then shows as a wrong `lk_taken`, which can be many cycles later. The bench therefore keeps a full shadow table per indexing mode and compares every lookup against it. It also steers PCs into a small region so that entries are revisited often. A wrong history shows on `lk_hist` one cycle after the faulty shift or restore. It also skews later gshare and gselect predictions, so history faults show up on both outputs.

// File: rtl/pkctr_pkg.sv
// Shared types and counter arithmetic for the packed-counter predictor.
// Assumes 2-bit counters, four per 8-bit storage word.
package pkctr_pkg;

    typedef enum logic [1:0] {
        IDX_BIMODAL = 2'd0,
        IDX_GSELECT = 2'd1,
        IDX_GSHARE  = 2'd2
    } idx_mode_e;

    localparam int          CTR_W     = 2;
    localparam int          FIELDS    = 4;
    localparam int          WORD_W    = CTR_W * FIELDS;
    localparam logic [1:0]  CTR_INIT  = 2'b01;

    // Saturating step of one 2-bit counter toward the observed outcome.
    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic up);
        if (up)
            return (cur == 2'b11) ? cur : cur + 2'b01;
        else
            return (cur == 2'b00) ? cur : cur - 2'b01;
    endfunction

endpackage

// File: rtl/pkctr_index.sv
// Index formation for the direction table.
// MODE picks bimodal, gselect or gshare. The PC is instruction-aligned,
// so its PC_LSB low bits are skipped. Gselect assumes HIST_W < IDX_W.
// Gshare assumes HIST_W <= IDX_W.
module pkctr_index
    import pkctr_pkg::*;
#(
    parameter int        PC_W   = 64,
    parameter int        IDX_W  = 12,
    parameter int        HIST_W = 8,
    parameter int        PC_LSB = 2,
    parameter idx_mode_e MODE   = IDX_GSHARE
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);

    localparam int SEL_PC_W = IDX_W - HIST_W;

    // Bits that a given mode does not consume.
    logic unused_inputs;
    assign unused_inputs = ^{pc, hist};

    generate
        if (MODE == IDX_BIMODAL) begin : g_bimodal
            // PC bits alone select the entry.
            assign idx = pc[PC_LSB +: IDX_W];
        end else if (MODE == IDX_GSELECT) begin : g_gselect
            // Upper index bits come from the PC and lower bits from the history.
            assign idx = {pc[PC_LSB +: SEL_PC_W], hist};
        end else begin : g_gshare
            // PC bits are folded with the zero-extended history.
            assign idx = pc[PC_LSB +: IDX_W] ^ IDX_W'(hist);
        end
    endgenerate

endmodule

// File: rtl/pkctr_ctr_mem.sv
// Counter storage: an 8-bit-wide array of 2^(IDX_W-2) words.
// The read port is asynchronous and returns the selected 2-bit field.
// The update port reads, modifies and writes back one field in a single
// cycle. A read in the same cycle as a write sees the old word.
module pkctr_ctr_mem
    import pkctr_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [1:0]       rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    localparam int                ADDR_W    = IDX_W - 2;
    localparam int                WORDS     = 1 << ADDR_W;
    localparam logic [WORD_W-1:0] WORD_INIT = {FIELDS{CTR_INIT}};

    logic [WORD_W-1:0] mem [WORDS];

    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [1:0]        rd_sel, wr_sel;
    logic [WORD_W-1:0] rd_word, wr_old, wr_new, wr_mask;

    // Split each index into a word address and a field select.
    assign rd_addr = rd_idx[IDX_W-1:2];
    assign rd_sel  = rd_idx[1:0];
    assign wr_addr = wr_idx[IDX_W-1:2];
    assign wr_sel  = wr_idx[1:0];

    // Lookup read: fetch the word and pick its field.
    assign rd_word = mem[rd_addr];
    assign rd_ctr  = rd_word[{rd_sel, 1'b0} +: CTR_W];

    // Update read: the word about to be modified, and the field's bit mask.
    assign wr_old  = mem[wr_addr];
    assign wr_mask = WORD_W'(8'b0000_0011) << {wr_sel, 1'b0};

    // Modify: step only the selected field and keep the other three.
    always_comb begin
        wr_new = wr_old;
        wr_new[{wr_sel, 1'b0} +: CTR_W] = ctr_step(wr_old[{wr_sel, 1'b0} +: CTR_W], wr_taken);
    end

    // Write back, or fill every word with weakly-not-taken on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= WORD_INIT;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_new;
        end
    end

    // R1
    reset_fill_chk: assert property (@(posedge clk)
        !rst_n |=> (mem[0] == WORD_INIT && mem[WORDS-1] == WORD_INIT));

    // R4
    field_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((mem[$past(wr_addr)] & ~$past(wr_mask)) ==
                   ($past(wr_old) & ~$past(wr_mask))));

    // R3
    sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && ((wr_old & wr_mask) == wr_mask)) |=>
        ((mem[$past(wr_addr)] & $past(wr_mask)) == $past(wr_mask)));

    // R3
    sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && ((wr_old & wr_mask) == '0)) |=>
        ((mem[$past(wr_addr)] & $past(wr_mask)) == '0));

endmodule

// File: rtl/pkctr_ghr.sv
// Speculative global history register.
// Each lookup shifts in its predicted direction. A mispredict reloads the
// history the branch carried and appends the real outcome. The restore
// wins over a shift in the same cycle. Assumes HIST_W >= 2.
module pkctr_ghr #(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    input  logic              restore_en,
    input  logic [HIST_W-1:0] restore_hist,
    input  logic              restore_bit,
    output logic [HIST_W-1:0] hist_q
);

    // History update: restore first, otherwise shift in the prediction.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist_q <= '0;
        else if (restore_en)
            hist_q <= {restore_hist[HIST_W-2:0], restore_bit};
        else if (shift_en)
            hist_q <= {hist_q[HIST_W-2:0], shift_bit};
    end

    // R1
    ghr_reset_chk: assert property (@(posedge clk) !rst_n |=> hist_q == '0);

    // R9
    spec_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !restore_en) |=> hist_q == {$past(hist_q[HIST_W-2:0]), $past(shift_bit)});

    // R10
    restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_en |=> hist_q == {$past(restore_hist[HIST_W-2:0]), $past(restore_bit)});

endmodule

// File: rtl/pkctr_bp.sv
// Packed-counter branch direction predictor (top).
// The lookup is combinational from lk_pc and the speculative history. The
// update is a one-cycle read-modify-write of one field of an 8-bit word.
// Assumes ENTRIES is a power of two of at least 16, and HIST_W < log2(ENTRIES)
// when gselect is chosen.
module pkctr_bp
    import pkctr_pkg::*;
#(
    parameter int        ENTRIES = 4096,
    parameter int        PC_W    = 64,
    parameter int        HIST_W  = 8,
    parameter int        PC_LSB  = 2,
    parameter idx_mode_e MODE    = IDX_GSHARE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              lk_taken,
    output logic [HIST_W-1:0] lk_hist,
    input  logic              up_valid,
    input  logic [PC_W-1:0]   up_pc,
    input  logic [HIST_W-1:0] up_hist,
    input  logic              up_taken,
    input  logic              up_mispred
);

    localparam int IDX_W = $clog2(ENTRIES);

    logic [IDX_W-1:0]  lk_idx, up_idx;
    logic [HIST_W-1:0] ghr_q;
    logic [1:0]        lk_ctr;

    // Lookup index from the fetch PC and the live speculative history.
    pkctr_index #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .PC_LSB(PC_LSB), .MODE(MODE))
        u_lk_index (.pc(lk_pc), .hist(ghr_q), .idx(lk_idx));

    // Update index from the resolved PC and the history carried with it.
    pkctr_index #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .PC_LSB(PC_LSB), .MODE(MODE))
        u_up_index (.pc(up_pc), .hist(up_hist), .idx(up_idx));

    // Packed counter table.
    pkctr_ctr_mem #(.IDX_W(IDX_W)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .rd_ctr   (lk_ctr),
        .wr_en    (up_valid),
        .wr_idx   (up_idx),
        .wr_taken (up_taken)
    );

    // Direction is the counter's upper bit; report the history used.
    assign lk_taken = lk_ctr[1];
    assign lk_hist  = ghr_q;

    // Speculative history with mispredict restore.
    pkctr_ghr #(.HIST_W(HIST_W)) u_ghr (
        .clk          (clk),
        .rst_n        (rst_n),
        .shift_en     (lk_valid),
        .shift_bit    (lk_taken),
        .restore_en   (up_valid & up_mispred),
        .restore_hist (up_hist),
        .restore_bit  (up_taken),
        .hist_q       (ghr_q)
    );

endmodule

// File: tb/pkctr_bp_tb_top.sv
// Bench: three predictors (bimodal 512, gselect 4096, gshare 4096) run on the
// same stimulus and are compared against a shadow counter table and history.
module pkctr_bp_tb_top;
    import pkctr_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, up_valid = 1'b0, up_taken = 1'b0, up_mispred = 1'b0;
    logic [63:0] lk_pc = '0, up_pc = '0;
    logic [7:0]  up_hist = '0;

    logic       tk_bim, tk_sel, tk_gsh;
    logic [7:0] hs_bim, hs_sel, hs_gsh;

    pkctr_bp #(.ENTRIES(512), .HIST_W(8), .MODE(IDX_BIMODAL)) dut_bim (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_taken(tk_bim),
        .lk_hist(hs_bim), .up_valid(up_valid), .up_pc(up_pc), .up_hist(up_hist),
        .up_taken(up_taken), .up_mispred(up_mispred));

    pkctr_bp #(.ENTRIES(4096), .HIST_W(8), .MODE(IDX_GSELECT)) dut_sel (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_taken(tk_sel),
        .lk_hist(hs_sel), .up_valid(up_valid), .up_pc(up_pc), .up_hist(up_hist),
        .up_taken(up_taken), .up_mispred(up_mispred));

    pkctr_bp dut_i (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_taken(tk_gsh),
        .lk_hist(hs_gsh), .up_valid(up_valid), .up_pc(up_pc), .up_hist(up_hist),
        .up_taken(up_taken), .up_mispred(up_mispred));

    // Shadow state per mode: 0 bimodal, 1 gselect, 2 gshare.
    logic [1:0] cm [3][4096];
    logic [7:0] gh [3];
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // Index per R5/R6/R7 with PC_LSB = 2, HIST_W = 8.
    function automatic int midx(int m, logic [63:0] pc, logic [7:0] h);
        case (m)
            0:       return int'(pc[10:2]);
            1:       return int'({pc[5:2], h});
            default: return int'(pc[13:2] ^ {4'b0, h});
        endcase
    endfunction

    function automatic logic [1:0] sat(logic [1:0] c, logic up);
        if (up) return (c == 2'd3) ? 2'd3 : c + 2'd1;
        return (c == 2'd0) ? 2'd0 : c - 2'd1;
    endfunction

    function automatic string mtag(int m);
        case (m)
            0:       return "R5";
            1:       return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic logic got_tk(int m);
        case (m) 0: return tk_bim; 1: return tk_sel; default: return tk_gsh; endcase
    endfunction

    function automatic logic [7:0] got_hs(int m);
        case (m) 0: return hs_bim; 1: return hs_sel; default: return hs_gsh; endcase
    endfunction

    task automatic chk(string req, string what, int m, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s mode%0d: actual %0h expected %0h", req, what, m, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int m = 0; m < 3; m++) begin
            gh[m] = '0;
            for (int i = 0; i < 4096; i++) cm[m][i] = CTR_INIT;
        end
    endtask

    // One cycle: drive at negedge, compare before posedge, advance the model after it.
    task automatic step(string tag, logic lv, logic [63:0] lpc, logic uv, logic [63:0] upc,
                        logic [7:0] uh, logic ut, logic um);
        logic et [3];
        @(negedge clk);
        lk_valid = lv; lk_pc = lpc; up_valid = uv; up_pc = upc;
        up_hist = uh; up_taken = ut; up_mispred = um;
        #1;
        for (int m = 0; m < 3; m++) begin
            et[m] = cm[m][midx(m, lpc, gh[m])][1];
            chk((tag == "") ? "R9" : tag, "lk_hist", m, 32'(got_hs(m)), 32'(gh[m]));
            if (lv) chk((tag == "") ? mtag(m) : tag, "lk_taken", m, 32'(got_tk(m)), 32'(et[m]));
        end
        @(posedge clk);
        for (int m = 0; m < 3; m++) begin
            if (uv) cm[m][midx(m, upc, uh)] = sat(cm[m][midx(m, upc, uh)], ut);
            if (uv && um) gh[m] = {uh[6:0], ut};
            else if (lv)  gh[m] = {gh[m][6:0], et[m]};
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; lk_valid = 0; up_valid = 0; up_mispred = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    localparam logic [63:0] BASE = 64'h0000_0000_8000_1000;

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R1: fresh table predicts not-taken everywhere, history starts at zero.
        for (int i = 0; i < 8; i++) step("R1", 1, BASE + 64'(i * 52), 0, '0, '0, 0, 0);

        // R3/R2: drive one entry to the top, past saturation, then look it up.
        for (int i = 0; i < 4; i++) step("R3", 0, '0, 1, BASE, 8'h00, 1, 0);
        step("R2", 1, BASE, 0, '0, '0, 0, 0);
        for (int i = 0; i < 5; i++) step("R3", 0, '0, 1, BASE, 8'h00, 0, 0);
        step("R3", 1, BASE, 0, '0, '0, 0, 0);

        // R4: strengthen the neighbour field, then read all four fields of the word.
        step("R4", 0, '0, 1, BASE + 64'd4, 8'h00, 1, 0);
        step("R4", 0, '0, 1, BASE + 64'd4, 8'h00, 1, 0);
        for (int k = 0; k < 4; k++) begin
            step("R10", 0, '0, 1, '0, 8'h00, 0, 1); // rewind history to zero
            step("R4", 1, BASE + 64'(k * 4), 0, '0, '0, 0, 0);
        end

        // R8: lookup and update to the same word in one cycle, then re-read.
        step("R10", 0, '0, 1, '0, 8'h00, 0, 1);
        step("R8", 1, BASE + 64'd8, 1, BASE + 64'd8, 8'h00, 1, 0);
        step("R8", 1, BASE + 64'd8, 1, BASE + 64'd8, 8'h00, 1, 0);
        step("R8", 0, '0, 1, BASE + 64'd12, 8'h00, 1, 0);
        step("R8", 0, '0, 1, BASE + 64'd12, 8'h00, 1, 0);
        step("R10", 0, '0, 1, '0, 8'h00, 0, 1);
        step("R8", 1, BASE + 64'd12, 0, '0, '0, 0, 0);

        // R10: mispredict restore alongside a lookup, then observe the history.
        step("R10", 1, BASE + 64'd4, 1, BASE, 8'hA5, 1, 1);
        step("R10", 1, BASE, 1, BASE + 64'd4, 8'h3C, 0, 1);
        step("R9", 1, BASE + 64'd4, 0, '0, '0, 0, 0);

        // R11 and R5/R6/R7: constrained random traffic over a small PC window.
        for (int i = 0; i < 4000; i++) begin
            logic [63:0] lp, upc;
            logic [7:0]  uh;
            lp  = BASE + 64'(($urandom % 48) * 4);
            upc = BASE + 64'(($urandom % 48) * 4);
            uh  = ($urandom % 4 == 0) ? 8'($urandom) : gh[2];
            step((i % 7 == 0) ? "R11" : "", ($urandom % 4) != 0, lp,
                 ($urandom % 3) != 0, upc, uh, ($urandom % 5) < 3, ($urandom % 9) == 0);
        end

        // R1: a second reset clears trained state.
        do_reset();
        for (int i = 0; i < 6; i++) step("R1", 1, BASE + 64'(i * 4), 0, '0, '0, 0, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule